// File: doc/BRIEF.md
# Shared-Page-Aware Instruction TLB

This block is a small fully associative instruction translation buffer for a front end that fetches for two hardware threads. Each entry carries a virtual page number, a physical page number, the process identifier of its owner, a valid bit and a shared flag. Shared entries hold pages of common libraries that several processes map at the same virtual address. An entry with the shared flag set answers a lookup from any process. A single copy of a library page therefore serves every thread, and the buffer does not need one process-tagged copy per process.

Each cycle the block takes at most one lookup, made of a virtual page and the requester's process identifier. One cycle later it returns a registered hit flag, the physical page, and the shared flag of the matching entry, which the instruction cache can copy into its line. A fill port installs a translation together with its shared flag, as set by the page-fault handler. A flush port invalidates the private translations of one process and leaves the shared ones in place.

Top module: `itlb_shared`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until a fill installs an entry.
- R2: A lookup hits only on a valid entry whose virtual page equals the requested one and whose process identifier equals the requester's, or on such an entry that has its shared flag set, whatever the requester's process identifier.
- R3: `outValid` is high exactly one cycle after a cycle with `lookValid` high. On a miss, `outPpn` and `outShared` are zero. `outHit` is never high while `outValid` is low.
- R4: On a hit, `outPpn` and `outShared` give the physical page and the shared flag stored with the matching entry.
- R5: A fill overwrites an existing valid entry with the same virtual page when that entry has the fill's process identifier or has its shared flag set. No second entry is allocated in that case.
- R6: If no existing entry matches as described in R5, a fill takes the lowest-numbered invalid entry.
- R7: If no entry matches and all 16 entries are valid, a fill replaces the entry chosen by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping after entry 15, only when it is used for a replacement.
- R8: A flush invalidates every entry whose process identifier equals `flushPid` and whose shared flag is clear. Shared entries survive.
- R9: A lookup in the same cycle as a fill or a flush sees the contents from before that fill or flush.
- R10: When a fill and a flush occur in the same cycle, the fill target is chosen on the pre-flush contents, the flush is applied, and then the fill is written, so the filled entry is valid.
- R11: When several valid entries match one lookup, the lowest-numbered entry supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookValid | input | 1 | Lookup request this cycle |
| lookVpn | input | VPN_W | Virtual page to translate |
| lookPid | input | PID_W | Process identifier of the requester |
| fillValid | input | 1 | Install a translation this cycle |
| fillVpn | input | VPN_W | Virtual page of the fill |
| fillPid | input | PID_W | Owning process of the fill |
| fillPpn | input | PPN_W | Physical page of the fill |
| fillShared | input | 1 | Marks the filled page as shared by all processes |
| flushValid | input | 1 | Flush private entries of one process this cycle |
| flushPid | input | PID_W | Process whose private entries are dropped |
| outValid | output | 1 | Lookup result present |
| outHit | output | 1 | Lookup found a translation |
| outPpn | output | PPN_W | Translated physical page, zero on a miss |
| outShared | output | 1 | Shared flag of the matching entry, zero on a miss |

## Verification
The assertions assume that reset is held low for at least two cycles and that fill and flush inputs are idle during reset. The property that follows a fill treats the filled page as the first match for that page and process. This holds because the fill target and the lookup match use the same rule and the same lowest-index order. The stimulus meets these conditions by driving every input to zero through reset. Random traffic draws pages from a range of eight values and process identifiers from three, so overwrites, shared hits across processes, duplicate matches and flushes of live entries occur often.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  // Strobes the control sends to the entry datapath each cycle.
  typedef struct packed {
    logic wrEn;   // write the selected entry with the fill data
    logic clrEn;  // invalidate private entries of flushPid
  } itlbCtl_t;
endpackage

// File: rtl/itlb_ctrl.sv
module itlb_ctrl
  import itlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               flushValid,
  input  logic [ENTRIES-1:0] fillHitVec,
  input  logic [ENTRIES-1:0] freeVec,
  output itlbCtl_t           ctl,
  output logic [IDX_W-1:0]   wrIdx
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] hitIdx, freeIdx;
  logic             useRr;

  // Lowest-index pick among matching and among free entries.
  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fillHitVec[i]) hitIdx  = IDX_W'(i);
      if (freeVec[i])    freeIdx = IDX_W'(i);
    end
  end

  always_comb begin
    useRr = 1'b0;
    if (|fillHitVec)   wrIdx = hitIdx;
    else if (|freeVec) wrIdx = freeIdx;
    else begin
      wrIdx = rrPtr;
      useRr = fillValid;
    end
    ctl.wrEn  = fillValid;
    ctl.clrEn = flushValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rrPtr <= '0;
    else if (useRr)
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
  end
endmodule

// File: rtl/itlb_store.sv
module itlb_store
  import itlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookValid,
  input  logic [VPN_W-1:0]   lookVpn,
  input  logic [PID_W-1:0]   lookPid,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PID_W-1:0]   fillPid,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic               fillShared,
  input  logic [PID_W-1:0]   flushPid,
  input  itlbCtl_t           ctl,
  input  logic [IDX_W-1:0]   wrIdx,
  output logic [ENTRIES-1:0] fillHitVec,
  output logic [ENTRIES-1:0] freeVec,
  output logic               outValid,
  output logic               outHit,
  output logic [PPN_W-1:0]   outPpn,
  output logic               outShared
);
  logic [ENTRIES-1:0] entValid, entShared;
  logic [PID_W-1:0]   entPid [ENTRIES];
  logic [VPN_W-1:0]   entVpn [ENTRIES];
  logic [PPN_W-1:0]   entPpn [ENTRIES];
  logic [ENTRIES-1:0] lookHitVec, flushVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : gEnt
    assign lookHitVec[i] = entValid[i] && entVpn[i] == lookVpn &&
                           (entShared[i] || entPid[i] == lookPid);
    assign fillHitVec[i] = entValid[i] && entVpn[i] == fillVpn &&
                           (entShared[i] || entPid[i] == fillPid);
    assign flushVec[i]   = entValid[i] && !entShared[i] && entPid[i] == flushPid;
    assign freeVec[i]    = !entValid[i];

    logic wrHere;
    assign wrHere = ctl.wrEn && wrIdx == IDX_W'(i);

    always_ff @(posedge clk) begin
      if (!rstN) entValid[i] <= 1'b0;
      else if (wrHere) entValid[i] <= 1'b1;
      else if (ctl.clrEn && flushVec[i]) entValid[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (wrHere) begin
        entShared[i] <= fillShared;
        entPid[i]    <= fillPid;
        entVpn[i]    <= fillVpn;
        entPpn[i]    <= fillPpn;
      end
    end
  end

  // Lowest matching index supplies the lookup result.
  logic             lkHit, lkShared;
  logic [PPN_W-1:0] lkPpn;
  always_comb begin
    lkHit    = 1'b0;
    lkShared = 1'b0;
    lkPpn    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lookHitVec[i]) begin
        lkHit    = 1'b1;
        lkShared = entShared[i];
        lkPpn    = entPpn[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outHit    <= 1'b0;
      outPpn    <= '0;
      outShared <= 1'b0;
    end else begin
      outValid  <= lookValid;
      outHit    <= lookValid && lkHit;
      outPpn    <= (lookValid && lkHit) ? lkPpn : '0;
      outShared <= lookValid && lkHit && lkShared;
    end
  end
endmodule

// File: rtl/itlb_shared.sv
module itlb_shared
  import itlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PID_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookValid,
  input  logic [VPN_W-1:0] lookVpn,
  input  logic [PID_W-1:0] lookPid,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PID_W-1:0] fillPid,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             fillShared,
  input  logic             flushValid,
  input  logic [PID_W-1:0] flushPid,
  output logic             outValid,
  output logic             outHit,
  output logic [PPN_W-1:0] outPpn,
  output logic             outShared
);
  localparam int IDX_W = $clog2(ENTRIES);

  itlbCtl_t           ctl;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] fillHitVec, freeVec;

  itlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .flushValid(flushValid),
    .fillHitVec(fillHitVec), .freeVec(freeVec), .ctl(ctl), .wrIdx(wrIdx)
  );

  itlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W)) u_store (
    .clk(clk), .rstN(rstN), .lookValid(lookValid), .lookVpn(lookVpn),
    .lookPid(lookPid), .fillVpn(fillVpn), .fillPid(fillPid), .fillPpn(fillPpn),
    .fillShared(fillShared), .flushPid(flushPid), .ctl(ctl), .wrIdx(wrIdx),
    .fillHitVec(fillHitVec), .freeVec(freeVec), .outValid(outValid),
    .outHit(outHit), .outPpn(outPpn), .outShared(outShared)
  );
endmodule

// File: rtl/itlb_chk.sv
module itlb_chk #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int PID_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookValid,
  input logic [VPN_W-1:0] lookVpn,
  input logic [PID_W-1:0] lookPid,
  input logic             fillValid,
  input logic [VPN_W-1:0] fillVpn,
  input logic [PID_W-1:0] fillPid,
  input logic [PPN_W-1:0] fillPpn,
  input logic             fillShared,
  input logic             flushValid,
  input logic [PID_W-1:0] flushPid,
  input logic             outValid,
  input logic             outHit,
  input logic [PPN_W-1:0] outPpn,
  input logic             outShared
);
  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> outValid == $past(lookValid));

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    !outHit |-> (outPpn == '0 && !outShared));

  assert_hit_needs_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    outHit |-> outValid);

  // R4, R5: a translation filled in the previous cycle is returned unchanged.
  assert_fill_visible_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && lookValid && $past(fillValid) && !$past(flushValid) &&
     lookVpn == $past(fillVpn) && lookPid == $past(fillPid))
    |=> (outHit && outPpn == $past(fillPpn, 2) && outShared == $past(fillShared, 2)));

  assert_shared_any_pid_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && lookValid && $past(fillValid) && $past(fillShared) &&
     !$past(flushValid) && lookVpn == $past(fillVpn)) |=> outHit);

  assert_flush_private_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && lookValid && $past(flushValid) && !$past(fillValid) &&
     lookPid == $past(flushPid)) |=> (!outHit || outShared));
endmodule

bind itlb_shared itlb_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W)) u_chk (
  .clk(clk), .rstN(rstN), .lookValid(lookValid), .lookVpn(lookVpn),
  .lookPid(lookPid), .fillValid(fillValid), .fillVpn(fillVpn), .fillPid(fillPid),
  .fillPpn(fillPpn), .fillShared(fillShared), .flushValid(flushValid),
  .flushPid(flushPid), .outValid(outValid), .outHit(outHit), .outPpn(outPpn),
  .outShared(outShared)
);

// File: tb/sim_itlb_shared.sv
module sim_itlb_shared;
  localparam int ENTRIES = 16;
  localparam int VPN_W = 20, PPN_W = 20, PID_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN, lookValid, fillValid, fillShared, flushValid;
  logic [VPN_W-1:0] lookVpn, fillVpn;
  logic [PID_W-1:0] lookPid, fillPid, flushPid;
  logic [PPN_W-1:0] fillPpn;
  logic             outValid, outHit, outShared;
  logic [PPN_W-1:0] outPpn;

  itlb_shared u0 (
    .clk(clk), .rstN(rstN), .lookValid(lookValid), .lookVpn(lookVpn),
    .lookPid(lookPid), .fillValid(fillValid), .fillVpn(fillVpn), .fillPid(fillPid),
    .fillPpn(fillPpn), .fillShared(fillShared), .flushValid(flushValid),
    .flushPid(flushPid), .outValid(outValid), .outHit(outHit), .outPpn(outPpn),
    .outShared(outShared)
  );

  int nCmp = 0, nBad = 0;

  // Reference contents built from the requirements.
  bit               mV [ENTRIES];
  bit               mS [ENTRIES];
  logic [PID_W-1:0] mPid [ENTRIES];
  logic [VPN_W-1:0] mVpn [ENTRIES];
  logic [PPN_W-1:0] mPpn [ENTRIES];
  int               mRr;

  function automatic bit mMatch(int i, logic [VPN_W-1:0] v, logic [PID_W-1:0] p);
    return mV[i] && mVpn[i] == v && (mS[i] || mPid[i] == p);
  endfunction

  // R2, R11: lowest matching entry answers.
  function automatic void mLook(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                                output bit h, output logic [PPN_W-1:0] pp, output bit s);
    h = 0; pp = '0; s = 0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (mMatch(i, v, p)) begin h = 1; pp = mPpn[i]; s = mS[i]; end
  endfunction

  // R5, R6, R7, R8, R10
  function automatic void mUpdate(bit fv, logic [VPN_W-1:0] fvpn, logic [PID_W-1:0] fpid,
                                  logic [PPN_W-1:0] fppn, bit fsh, bit xv, logic [PID_W-1:0] xpid);
    int tgt = -1;
    if (fv) begin
      for (int i = ENTRIES - 1; i >= 0; i--) if (mMatch(i, fvpn, fpid)) tgt = i;
      if (tgt < 0) for (int i = ENTRIES - 1; i >= 0; i--) if (!mV[i]) tgt = i;
      if (tgt < 0) begin tgt = mRr; mRr = (mRr + 1) % ENTRIES; end
    end
    if (xv) for (int i = 0; i < ENTRIES; i++) if (mV[i] && !mS[i] && mPid[i] == xpid) mV[i] = 0;
    if (fv) begin
      mV[tgt] = 1; mS[tgt] = fsh; mPid[tgt] = fpid; mVpn[tgt] = fvpn; mPpn[tgt] = fppn;
    end
  endfunction

  // One cycle: drive at a falling edge, check at the next falling edge.
  task automatic step(bit lv, logic [VPN_W-1:0] lvpn, logic [PID_W-1:0] lpid,
                      bit fv, logic [VPN_W-1:0] fvpn, logic [PID_W-1:0] fpid,
                      logic [PPN_W-1:0] fppn, bit fsh, bit xv, logic [PID_W-1:0] xpid,
                      string tag);
    bit eh, es;
    logic [PPN_W-1:0] ep;
    lookValid = lv; lookVpn = lvpn; lookPid = lpid;
    fillValid = fv; fillVpn = fvpn; fillPid = fpid; fillPpn = fppn; fillShared = fsh;
    flushValid = xv; flushPid = xpid;
    mLook(lvpn, lpid, eh, ep, es);
    if (!lv) begin eh = 0; ep = '0; es = 0; end
    mUpdate(fv, fvpn, fpid, fppn, fsh, xv, xpid);
    @(negedge clk);
    if (lv) begin
      nCmp++;
      if (outValid !== 1'b1 || outHit !== eh || outPpn !== ep || outShared !== es) begin
        nBad++;
        $display("FAIL %s: vpn=%0h pid=%0d act v/h/ppn/s=%b/%b/%0h/%b exp 1/%b/%0h/%b",
                 tag, lvpn, lpid, outValid, outHit, outPpn, outShared, eh, ep, es);
      end
    end
  endtask

  task automatic look(logic [VPN_W-1:0] v, logic [PID_W-1:0] p, string tag);
    step(1, v, p, 0, '0, '0, '0, 0, 0, '0, tag);
  endtask

  task automatic fill(logic [VPN_W-1:0] v, logic [PID_W-1:0] p, logic [PPN_W-1:0] pp,
                      bit s);
    step(0, '0, '0, 1, v, p, pp, s, 0, '0, "fill");
  endtask

  task automatic expectHit(bit e, string tag);
    nCmp++;
    if (outHit !== e) begin
      nBad++;
      $display("FAIL %s: hit act %b exp %b", tag, outHit, e);
    end
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin mV[i] = 0; mS[i] = 0; end
    mRr = 0;
    rstN = 0; lookValid = 0; lookVpn = '0; lookPid = '0; fillValid = 0; fillVpn = '0;
    fillPid = '0; fillPpn = '0; fillShared = 0; flushValid = 0; flushPid = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    nCmp++;
    if (outValid !== 1'b0 || outHit !== 1'b0) begin
      nBad++;
      $display("FAIL R3 reset: valid/hit act %b/%b exp 0/0", outValid, outHit);
    end
    look(20'h5, 8'd1, "R1 empty");
    expectHit(0, "R1 empty");
    // Shared page visible to other processes; private one is not.
    fill(20'h5, 8'd1, 20'hAAA, 1);
    look(20'h5, 8'd2, "R2 shared other pid");
    expectHit(1, "R2 shared other pid");
    fill(20'h6, 8'd1, 20'hBBB, 0);
    look(20'h6, 8'd2, "R2 private other pid");
    expectHit(0, "R2 private other pid");
    look(20'h6, 8'd1, "R4 private owner");
    // Same-cycle fill and lookup sees the old contents.
    step(1, 20'h7, 8'd1, 1, 20'h7, 8'd1, 20'hC07, 0, 0, '0, "R9 fill same cycle");
    expectHit(0, "R9 fill same cycle");
    look(20'h7, 8'd1, "R9 after fill");
    // Overwrite of an existing match.
    fill(20'h6, 8'd1, 20'hCCC, 0);
    look(20'h6, 8'd1, "R5 overwrite");
    fill(20'h5, 8'd3, 20'hDDD, 0);
    look(20'h5, 8'd2, "R5 overwrite shared");
    // Flush spares shared entries.
    fill(20'h8, 8'd1, 20'hE08, 1);
    step(1, 20'h6, 8'd1, 0, '0, '0, '0, 0, 1, 8'd1, "R9 flush same cycle");
    look(20'h6, 8'd1, "R8 private flushed");
    expectHit(0, "R8 private flushed");
    look(20'h8, 8'd1, "R8 shared survives");
    expectHit(1, "R8 shared survives");
    // Fill and flush together.
    step(0, '0, '0, 1, 20'h9, 8'd2, 20'hF09, 0, 1, 8'd2, "R10");
    look(20'h9, 8'd2, "R10 fill wins");
    expectHit(1, "R10 fill wins");
    // Duplicate match: private for pid 1, shared from pid 2 on the same page.
    fill(20'h40, 8'd1, 20'h111, 0);
    fill(20'h40, 8'd2, 20'h222, 1);
    look(20'h40, 8'd1, "R11 lowest index");
    // Fill the whole buffer, then force round-robin replacement.
    for (int i = 0; i < ENTRIES; i++) fill(20'h100 + i, 8'd3, 20'h300 + i, 0);
    for (int i = 0; i < 3; i++) fill(20'h200 + i, 8'd3, 20'h400 + i, 0);
    for (int i = 0; i < ENTRIES; i++) look(20'h100 + i, 8'd3, "R7 victim");
    for (int i = 0; i < 3; i++) look(20'h200 + i, 8'd3, "R7 newcomer");
    for (int i = 0; i < 3; i++) look(20'h5 + i, 8'd1, "R6 R7 early");
    // Random traffic on a narrow page and process range.
    for (int n = 0; n < 4000; n++) begin
      automatic int r = $urandom % 100;
      step(r < 75, VPN_W'($urandom % 8), PID_W'($urandom % 3),
           r >= 45, VPN_W'($urandom % 8), PID_W'($urandom % 3),
           PPN_W'($urandom), ($urandom % 4) == 0,
           ($urandom % 20) == 0, PID_W'($urandom % 3), "R2 R4 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule